// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a digital sample word into the on/off controls of a segmented current-steering converter. The word is split into two fields. The upper field is expanded into a thermometer count of equal unit cells. The lower field goes unchanged to a small set of binary-weighted cells. The unit cells are not lit in index order. They start at the middle cell of the row and then alternate one step down and one step up, moving outward. A linear process gradient across the row therefore cancels in pairs instead of building up.

The input word is captured in a register. After decoding, every cell control passes through one shared output register, so all switches move on the same clock edge. This keeps timing skew between cells from producing glitches at the output. Latency is fixed at two clock edges for every code. A synchronous reset forces all controls low, which is zero-scale output.

Top module: `dac_seg_decoder`

## Requirements
- R1: The word is split so that its upper THERM_W bits form the unit field and its lower WORD_W-THERM_W bits form the binary field. The default is 8 bits split 4 + 4, so code 0xF0 lights all 15 unit cells with no binary bit, and 0x0F lights no unit cell with all four binary bits.
- R2: The number of asserted bits on `unit_en` equals the value of the unit field, from 0 up to 2^THERM_W-1.
- R3: The set of lit unit cells is cumulative. For any two unit field values a <= b, every cell lit for a is also lit for b.
- R4: `bin_en` equals the binary field bit for bit, with bit i driving the cell of weight 2^i.
- R5: Unit cells light in centre-out order. Let c = (2^THERM_W-2)/2 be the zero-based index of the middle cell. Cell c lights first, then c-1, c+1, c-2, c+2, and so on to both ends. With the default 15 cells, a field of 1 gives `unit_en` = 0x0080 and a field of 2 gives 0x00C0.
- R6: A word driven before clock edge t appears on the outputs right after edge t+1 and not earlier, whatever the code.
- R7: When `rst` is high at a clock edge, every `unit_en` and `bin_en` bit is 0 after that edge.
- R8: All UNITS + BIN_W controls change only on the active clock edge. A change of `code_in` in the middle of a cycle leaves the outputs steady until the edges of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | WORD_W | Sample word to be converted |
| unit_en | output | 2^THERM_W-1 | Per-cell enables of the unit cells, indexed by physical position |
| bin_en | output | WORD_W-THERM_W | Enables of the binary-weighted cells, bit i of weight 2^i |

## Verification
The bench steps through every code in ascending order, so each thermometer step is checked for exact count and for growth only. A decoder with an off-by-one compare would show one cell too many or too few, and a wrong order table would drop a lit cell when the code grows. Single-cell and two-cell codes pin down the physical centre-out positions; a sequential or mirrored order would light bit 0 or bit 14 instead of bit 7. A word changed in the middle of a cycle exposes a missing or extra pipeline stage, or an unregistered output, because the outputs would move one edge early or late. A reset in the middle of the run, while full scale is held, must clear every control at once.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;

  // zero-based index of the middle cell of an odd-length row
  function automatic int unsigned centre_of(input int unsigned units);
    return (units - 1) / 2;
  endfunction

  // turn-on rank of physical cell idx under centre-out ordering:
  // centre is rank 0, cells below take odd ranks, cells above even ranks
  function automatic int unsigned rank_of(input int unsigned idx,
                                          input int unsigned units);
    int unsigned c;
    c = centre_of(units);
    if (idx == c)      return 0;
    else if (idx < c)  return 2 * (c - idx) - 1;
    else               return 2 * (idx - c);
  endfunction

endpackage

// File: rtl/dac_in_reg.sv
module dac_in_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/dac_therm_dec.sv
module dac_therm_dec #(
  parameter int LVL_W = 4,
  localparam int OUT_W = (1 << LVL_W) - 1
) (
  input  logic [LVL_W-1:0] level,
  output logic [OUT_W-1:0] therm
);
  // position i is lit when the level exceeds i
  for (genvar i = 0; i < OUT_W; i++) begin : g_pos
    assign therm[i] = (int'(level) > i);
  end
endmodule

// File: rtl/dac_centre_map.sv
module dac_centre_map
  import dac_seg_pkg::*;
#(
  parameter int UNITS = 15
) (
  input  logic [UNITS-1:0] therm,
  output logic [UNITS-1:0] phys
);
  // physical cell e follows the thermometer position equal to its rank
  for (genvar e = 0; e < UNITS; e++) begin : g_cell
    localparam int unsigned RANK = rank_of(e, UNITS);
    assign phys[e] = therm[RANK];
  end
endmodule

// File: rtl/dac_retime_reg.sv
module dac_retime_reg #(
  parameter int UNIT_W = 15,
  parameter int BIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UNIT_W-1:0] unit_d,
  input  logic [BIN_W-1:0]  bin_d,
  output logic [UNIT_W-1:0] unit_q,
  output logic [BIN_W-1:0]  bin_q
);
  // one shared register for every cell control
  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q <= '0;
      bin_q  <= '0;
    end else begin
      unit_q <= unit_d;
      bin_q  <= bin_d;
    end
  end

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (unit_q == '0 && bin_q == '0));
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
  import dac_seg_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int THERM_W = 4,
  localparam int BIN_W  = WORD_W - THERM_W,
  localparam int UNITS  = (1 << THERM_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] code_in,
  output logic [UNITS-1:0]  unit_en,
  output logic [BIN_W-1:0]  bin_en
);
  localparam int unsigned CENTRE = centre_of(UNITS);

  logic [WORD_W-1:0]  held_code;
  logic [THERM_W-1:0] unit_field;
  logic [BIN_W-1:0]   bin_field;
  logic [UNITS-1:0]   therm_vec;
  logic [UNITS-1:0]   phys_vec;
  logic               primed;
  logic               primed2;

  // stage 1: capture the word
  dac_in_reg #(.WIDTH(WORD_W)) i_in_reg (
    .clk (clk),
    .rst (rst),
    .d   (code_in),
    .q   (held_code)
  );

  // R1: field split
  assign unit_field = held_code[WORD_W-1 -: THERM_W];
  assign bin_field  = held_code[BIN_W-1:0];

  dac_therm_dec #(.LVL_W(THERM_W)) i_therm (
    .level (unit_field),
    .therm (therm_vec)
  );

  dac_centre_map #(.UNITS(UNITS)) i_map (
    .therm (therm_vec),
    .phys  (phys_vec)
  );

  // stage 2: common retiming of all controls
  dac_retime_reg #(.UNIT_W(UNITS), .BIN_W(BIN_W)) i_retime (
    .clk    (clk),
    .rst    (rst),
    .unit_d (phys_vec),
    .bin_d  (bin_field),
    .unit_q (unit_en),
    .bin_q  (bin_en)
  );

  // history of non-reset edges, used to qualify the checks below
  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      primed2 <= 1'b0;
    end else begin
      primed  <= 1'b1;
      primed2 <= primed;
    end
  end

  assert_therm_shape_R3: assert property (@(posedge clk) disable iff (rst)
    primed |-> ((therm_vec & (therm_vec + UNITS'(1))) == '0));

  assert_unit_count_R2: assert property (@(posedge clk) disable iff (rst)
    primed |-> ($countones(unit_en) == int'($past(unit_field))));

  assert_bin_pass_R4: assert property (@(posedge clk) disable iff (rst)
    primed |-> (bin_en == $past(bin_field)));

  assert_cumulative_R3: assert property (@(posedge clk) disable iff (rst)
    (primed2 && ($past(unit_field) >= $past(unit_field, 2)))
      |-> (($past(unit_en) & ~unit_en) == '0));

  assert_centre_first_R5: assert property (@(posedge clk) disable iff (rst)
    (unit_en != '0) |-> unit_en[CENTRE]);

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    primed2 |-> (bin_en == $past(code_in[BIN_W-1:0], 2)));
endmodule

// File: tb/test_dac_seg_decoder.sv
`timescale 1ns/1ps
module test_dac_seg_decoder;
  localparam int WORD_W  = 8;
  localparam int THERM_W = 4;
  localparam int BIN_W   = WORD_W - THERM_W;
  localparam int UNITS   = (1 << THERM_W) - 1;
  localparam real HALF   = 4.0;   // 125 MHz

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [WORD_W-1:0] code_in = '0;
  logic [UNITS-1:0]  unit_en;
  logic [BIN_W-1:0]  bin_en;

  int checks = 0;
  int fails  = 0;
  int order_tab [UNITS];
  logic [WORD_W-1:0] exp_q [$];
  logic [UNITS-1:0]  prev_units = '0;
  int                prev_lvl   = 0;

  always #(HALF) clk = ~clk;

  dac_seg_decoder #(.WORD_W(WORD_W), .THERM_W(THERM_W)) i_dac_seg_decoder (
    .clk     (clk),
    .rst     (rst),
    .code_in (code_in),
    .unit_en (unit_en),
    .bin_en  (bin_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // centre-out list built by walking outward from the middle
  task automatic build_order();
    int lo, hi, n;
    lo = (UNITS - 1) / 2; hi = lo; n = 0;
    order_tab[n++] = lo;
    while (lo > 0 || hi < UNITS - 1) begin
      if (lo > 0)         begin lo--; order_tab[n++] = lo; end
      if (hi < UNITS - 1) begin hi++; order_tab[n++] = hi; end
    end
  endtask

  function automatic logic [UNITS-1:0] exp_units(input int lvl);
    logic [UNITS-1:0] v;
    v = '0;
    for (int j = 0; j < lvl; j++) v[order_tab[j]] = 1'b1;
    return v;
  endfunction

  // monitor side of the scoreboard
  task automatic compare(input logic [WORD_W-1:0] c);
    int lvl;
    lvl = int'(c[WORD_W-1 -: THERM_W]);
    check("R2 unit count", $countones(unit_en), lvl);
    check("R5 cell order", 32'(unit_en), 32'(exp_units(lvl)));
    check("R4 binary bits", 32'(bin_en), 32'(c[BIN_W-1:0]));
    if (lvl >= prev_lvl)
      check("R3 cumulative", 32'(prev_units & ~unit_en), 0);
    prev_units = unit_en;
    prev_lvl   = lvl;
  endtask

  // driver side: drives at a falling edge and pushes the expectation
  task automatic step(input logic [WORD_W-1:0] c);
    @(negedge clk);
    if (exp_q.size() == 2) compare(exp_q.pop_front());
    code_in = c;
    exp_q.push_back(c);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    build_order();
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 reset unit", 32'(unit_en), 0);
    check("R7 reset bin", 32'(bin_en), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R6 / R8: change mid-cycle, outputs move exactly two edges later
    code_in = 8'hA5;
    @(negedge clk);
    check("R8 held after one edge unit", 32'(unit_en), 0);
    check("R6 held after one edge bin", 32'(bin_en), 0);
    @(negedge clk);
    check("R6 two-edge latency unit", 32'(unit_en), 32'(exp_units(10)));
    check("R6 two-edge latency bin", 32'(bin_en), 5);
    code_in = 8'h00;
    repeat (2) @(negedge clk);

    // R5: literal positions for one and two cells
    code_in = 8'h10;
    repeat (2) @(negedge clk);
    check("R5 first cell is centre", 32'(unit_en), 32'h0080);
    code_in = 8'h20;
    repeat (2) @(negedge clk);
    check("R5 second cell below centre", 32'(unit_en), 32'h00C0);
    code_in = 8'h00;
    repeat (2) @(negedge clk);
    prev_units = '0; prev_lvl = 0;

    // R1: field split corners
    step(8'hF0); step(8'h0F); step(8'h80); step(8'h00);
    step(8'hF0); step(8'h0F);
    // R1 direct
    repeat (2) @(negedge clk);
    exp_q.delete();
    check("R1 low field only unit", 32'(unit_en), 0);
    check("R1 low field only bin", 32'(bin_en), 32'hF);
    prev_units = '0; prev_lvl = 0;

    // ascending sweep of every code (R2, R3, R4, R5)
    for (int k = 0; k < 256; k++) step(8'(k));
    // scattered codes
    lfsr = 8'h5B;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr);
    end
    step(8'h7F); step(8'h80); step(8'hFF);
    step(8'hFF); step(8'hFF);

    // R7: reset while full scale is held
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid-run reset unit", 32'(unit_en), 0);
    check("R7 mid-run reset bin", 32'(bin_en), 0);
    rst = 1'b0;
    exp_q.delete();
    code_in = '0;
    prev_units = '0; prev_lvl = 0;
    step(8'h3C); step(8'hC3); step(8'h00); step(8'h00);
    finish_run();
  end
endmodule